// File: doc/BRIEF.md
# Masked-Write GPIO Bank Port

This block is one 32-pin general-purpose I/O bank sitting behind a simple register bus made of an address, a write strobe, a write word and a combinational read word. Software sets each pin's output level, its direction and its driver enable. Software also reads back the synchronized logic level present on the pads.

The output level register can be changed in three ways: replacing the whole word, or writing one of two half-word "masked" ports. In a masked word the upper half carries a per-bit keep mask (1 = keep, 0 = write) and the lower half carries the new levels. One bus write can therefore change a single pin without a read-modify-write. A pad is actively driven only when both its direction bit and its driver-enable bit are 1. A parameter can pin selected pins (pins 7 and 8 by default) permanently in output direction.

The register bus is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_we` is high. `bus_rdata` always shows the register selected by `bus_addr`.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset the output level and driver-enable registers are 0, `pad_oe` is all 0, and the direction register reads back only the pinned bits (0x0000_0180 by default).
- R2: A write to offset 0x000 updates only pins 0..15. Pin i takes `bus_wdata[i]` when `bus_wdata[16+i]` is 0 and keeps its level when that bit is 1. Pins 16..31 are unchanged.
- R3: A write to offset 0x004 updates only pins 16..31. Pin 16+i takes `bus_wdata[i]` when `bus_wdata[16+i]` is 0 and keeps its level when that bit is 1. Pins 0..15 are unchanged.
- R4: A write to offset 0x040 replaces all 32 output levels, and a read of 0x040 returns them.
- R5: A read of offset 0x060 returns the pad levels through a two-flop synchronizer: the value present at clock edge n is readable after edge n+1. It never returns the output register.
- R6: Offset 0x204 is the direction register (1 = output, 0 = input), readable and writable.
- R7: Offset 0x208 is the driver-enable register, and `pad_oe[i]` is 1 exactly when direction bit i and enable bit i are both 1.
- R8: Direction bits of pinned pins (parameter `PINNED`, default pins 7 and 8) always read 1, and writes of 0 to them are ignored.
- R9: A read of 0x000 returns output pins 0..15 in bits 15:0, and a read of 0x004 returns pins 16..31 in bits 15:0. Bits 31:16 read 0 for both.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets or to 0x060 change no register.
- R11: `pad_out` always equals the output level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word for `bus_addr` |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Driver enable per pin (1 = drive) |

## Verification
The masked ports are tried with all-ones keep masks, which must change nothing, and with all-zeros masks, which must load a full half. They are also tried with single-zero masks, which isolate one pin, and with random masks, which separate the keep and write paths bit by bit. Full-word writes are interleaved so that a half-port leaking into the other half shows up at once on `pad_out`. Pad inputs change while the output register holds a different pattern, so the input read is checked against both the latency and the source. Writes of zero to the direction register and writes to read-only and unmapped offsets show whether pinned bits and silent addresses stay untouched.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam logic [11:0] OFS_MASK_LO = 12'h000;
  localparam logic [11:0] OFS_MASK_HI = 12'h004;
  localparam logic [11:0] OFS_LEVEL   = 12'h040;
  localparam logic [11:0] OFS_PINS    = 12'h060;
  localparam logic [11:0] OFS_DIR     = 12'h204;
  localparam logic [11:0] OFS_DRVEN   = 12'h208;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_LEVEL,
    SEL_PINS,
    SEL_DIR,
    SEL_DRVEN
  } reg_sel_e;
endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
  import gpio_mw_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_MASK_LO))      sel = SEL_MASK_LO;
    else if (addr == ADDR_W'(OFS_MASK_HI)) sel = SEL_MASK_HI;
    else if (addr == ADDR_W'(OFS_LEVEL))   sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_PINS))    sel = SEL_PINS;
    else if (addr == ADDR_W'(OFS_DIR))     sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_DRVEN))   sel = SEL_DRVEN;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_regs.sv
module gpio_mw_regs
  import gpio_mw_pkg::*;
#(
  parameter int unsigned     NPINS  = 32,
  parameter logic [NPINS-1:0] PINNED = 'h180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] level_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] drven_q
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] level_d;
  logic [HALF-1:0]  keep;
  logic [HALF-1:0]  newbits;

  assign keep    = wdata[NPINS-1:HALF];
  assign newbits = wdata[HALF-1:0];

  // output level: full replace or per-half masked merge
  always_comb begin
    level_d = level_q;
    if (we) begin
      unique case (sel)
        SEL_LEVEL:   level_d = wdata;
        SEL_MASK_LO: level_d[HALF-1:0] =
                       (level_q[HALF-1:0] & keep) | (newbits & ~keep);
        SEL_MASK_HI: level_d[NPINS-1:HALF] =
                       (level_q[NPINS-1:HALF] & keep) | (newbits & ~keep);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      drven_q <= '0;
    end else begin
      level_q <= level_d;
      if (we && sel == SEL_DRVEN) drven_q <= wdata;
    end
  end

  // direction: pinned bits are constant 1, the rest are flops
  for (genvar g = 0; g < NPINS; g++) begin : g_dir
    if (PINNED[g]) begin : g_pinned
      assign dir_q[g] = 1'b1;
    end else begin : g_free
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else if (we && sel == SEL_DIR) bit_q <= wdata[g];
      end
      assign dir_q[g] = bit_q;
    end
  end
endmodule

// File: rtl/gpio_mw_rdmux.sv
module gpio_mw_rdmux
  import gpio_mw_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  reg_sel_e         sel,
  input  logic [NPINS-1:0] level_q,
  input  logic [NPINS-1:0] pin_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] drven_q,
  output logic [NPINS-1:0] rdata
);
  localparam int unsigned HALF = NPINS / 2;

  always_comb begin
    unique case (sel)
      SEL_MASK_LO: rdata = {{HALF{1'b0}}, level_q[HALF-1:0]};
      SEL_MASK_HI: rdata = {{HALF{1'b0}}, level_q[NPINS-1:HALF]};
      SEL_LEVEL:   rdata = level_q;
      SEL_PINS:    rdata = pin_q;
      SEL_DIR:     rdata = dir_q;
      SEL_DRVEN:   rdata = drven_q;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int unsigned      NPINS  = 32,
  parameter int unsigned      ADDR_W = 12,
  parameter int unsigned      SYNC_N = 2,
  parameter logic [NPINS-1:0] PINNED = 'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  reg_sel_e         sel;
  logic [NPINS-1:0] level_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] drven_q;
  logic [NPINS-1:0] pin_q;

  gpio_mw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_mw_regs #(.NPINS(NPINS), .PINNED(PINNED)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .sel     (sel),
    .wdata   (bus_wdata),
    .level_q (level_q),
    .dir_q   (dir_q),
    .drven_q (drven_q)
  );

  gpio_mw_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_q)
  );

  gpio_mw_rdmux #(.NPINS(NPINS)) u_rd (
    .sel     (sel),
    .level_q (level_q),
    .pin_q   (pin_q),
    .dir_q   (dir_q),
    .drven_q (drven_q),
    .rdata   (bus_rdata)
  );

  assign pad_out = level_q;
  assign pad_oe  = dir_q & drven_q;
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk
  import gpio_mw_pkg::*;
#(
  parameter int unsigned      NPINS  = 32,
  parameter int unsigned      ADDR_W = 12,
  parameter logic [NPINS-1:0] PINNED = 'h180
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pin_q,
  input logic [NPINS-1:0]  dir_q
);
  localparam int unsigned HALF = NPINS / 2;

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r2_low_port_spares_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_MASK_LO)) |=>
      pad_out[NPINS-1:HALF] == $past(pad_out[NPINS-1:HALF]));

  a_r3_high_port_spares_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_MASK_HI)) |=>
      pad_out[HALF-1:0] == $past(pad_out[HALF-1:0]));

  a_r4_full_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_LEVEL)) |=> pad_out == $past(bus_wdata));

  a_r5_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> pin_q == $past(pad_in, 2));

  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> dir_q == ($past(bus_wdata) | PINNED));

  a_r10_pins_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_PINS)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .PINNED(PINNED)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pin_q     (pin_q),
  .dir_q     (dir_q)
);

// File: tb/gpio_mw_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mw_bank_tb_top;
  localparam logic [31:0] PIN_FIX = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_lvl, m_dir, m_en, ms1, ms2;

  always #10 clk = ~clk;

  gpio_mw_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // requirement R5 model: pad level readable after two edges
  always @(posedge clk) begin
    if (!rst_n) begin ms1 <= '0; ms2 <= '0; end
    else begin ms1 <= pad_in; ms2 <= ms1; end
  end

  function automatic logic [15:0] merge16(logic [15:0] old, logic [31:0] w);
    logic [15:0] r = old;
    for (int i = 0; i < 16; i++) if (!w[16+i]) r[i] = w[i];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a)
      12'h000: return {16'h0, m_lvl[15:0]};
      12'h004: return {16'h0, m_lvl[31:16]};
      12'h040: return m_lvl;
      12'h060: return ms2;
      12'h204: return m_dir;
      12'h208: return m_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      12'h000: m_lvl[15:0]  = merge16(m_lvl[15:0], d);
      12'h004: m_lvl[31:16] = merge16(m_lvl[31:16], d);
      12'h040: m_lvl = d;
      12'h204: m_dir = d | PIN_FIX;
      12'h208: m_en = d;
      default: ;
    endcase
    chk("R11 pad_out", pad_out, m_lvl);
    chk("R7 pad_oe", pad_oe, m_dir & m_en);
  endtask

  task automatic bus_check(string req, logic [11:0] a);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [11:0] adr_set [8];
    void'($urandom(32'd20240611));
    m_lvl = '0; m_dir = PIN_FIX; m_en = '0;
    adr_set = '{12'h000, 12'h004, 12'h040, 12'h060, 12'h204, 12'h208, 12'h00C, 12'h100};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    bus_check("R1 dir reset", 12'h204);
    bus_check("R1 en reset", 12'h208);

    // R4 full write, R9 half reads
    bus_write(12'h040, 32'hA5A5_3C3C);
    bus_check("R4 full read", 12'h040);
    bus_check("R9 low half read", 12'h000);
    bus_check("R9 high half read", 12'h004);
    // R2 all-keep mask: no change
    bus_write(12'h000, 32'hFFFF_0000);
    chk("R2 keep all", pad_out, 32'hA5A5_3C3C);
    // R2 all-write mask
    bus_write(12'h000, 32'h0000_1234);
    chk("R2 write all low", pad_out, 32'hA5A5_1234);
    // R3 single pin 31 set low
    bus_write(12'h004, 32'h7FFF_0000);
    chk("R3 single pin", pad_out, 32'h25A5_1234);
    // R8 pinned direction
    bus_write(12'h204, 32'h0000_0000);
    bus_check("R8 pinned dir", 12'h204);
    // R6, R7
    bus_write(12'h204, 32'hF0F0_0001);
    bus_write(12'h208, 32'hFF00_0181);
    chk("R7 oe and", pad_oe, 32'hF000_0181);
    bus_check("R6 dir read", 12'h204);
    // R10 writes to input and unmapped offsets
    bus_write(12'h060, 32'hFFFF_FFFF);
    bus_write(12'h07C, 32'hFFFF_FFFF);
    chk("R10 inert write", pad_out, 32'h25A5_1234);
    bus_check("R10 unmapped read", 12'h07C);
    // R5 input path shows pads, not output register
    @(negedge clk); pad_in = 32'h0F0F_F0F0;
    @(negedge clk);
    bus_check("R5 input latency", 12'h060);
    repeat (2) @(negedge clk);
    bus_check("R5 input settled", 12'h060);
    chk("R5 value", bus_rdata, 32'h0F0F_F0F0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = adr_set[$urandom_range(0, 7)];
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[31:16] = ~(16'h1 << $urandom_range(0, 15));
      if ($urandom_range(0, 4) == 0) pad_in = $urandom;
      bus_write(a, d);
      bus_check("R2 R3 R4 R5 R6 R9 R10 random read", adr_set[$urandom_range(0, 7)]);
    end
    finish_run();
  end
endmodule